// File: doc/BRIEF.md
# Segmented DAC Switch-Control Decoder

This block is the digital front end of a 12-bit current-steering converter. On every rising clock edge it registers a parallel input sample and splits it into three fields. The upper five bits go through a unary decoder that produces 31 thermometer enables for the coarse cells. The middle five bits become binary-weighted cell enables without change. The two lowest bits drive a separate group of fine cells.

A second register stage, clocked on the falling edge, aligns all switch enables so that they change on one edge, half a cycle after capture. A high-active sleep input turns every cell enable off at that stage. Capture continues during sleep, so the falling edge after sleep is released shows the newest sample. An active-low synchronous reset clears both stages.

Top module: `segdac_decoder`

## Requirements
- R1: `sample` is registered on every rising edge of `clk`. Field layout: bits [11:7] are the coarse code, bits [6:2] are the binary field and bits [1:0] are the fine field.
- R2: Thermometer line `therm_en[k]` (k = 0..30) is high exactly when the coarse code is greater than k. Code 0 enables no line and code 31 enables all 31 lines.
- R3: `bin_en` equals the registered bits [6:2] and `fine_en` equals the registered bits [1:0], in the same bit order.
- R4: Each thermometer line weighs 128 units, `bin_en[i]` weighs 2^(i+2) units and `fine_en[j]` weighs 2^j units. The weighted sum equals the registered code, so a larger code never enables fewer units.
- R5: All enables update together on the falling edge that follows the capturing rising edge. Between the capturing rising edge and that falling edge they keep the previous sample's value.
- R6: If `sleep` is high at a falling edge, every enable is low after that edge, whatever the input.
- R7: At the first falling edge with `sleep` low, the enables show the decode of the most recently captured sample.
- R8: With `rst_n` low, the rising edge clears the capture stage and the falling edge clears every enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock. Rising edge captures, falling edge updates the enables |
| rst_n | input | 1 | Active-low synchronous reset for both stages |
| sleep | input | 1 | High forces all enables off |
| sample | input | 12 | Parallel input code |
| therm_en | output | 31 | Thermometer enables for the coarse cells |
| bin_en | output | 5 | Binary-weighted cell enables |
| fine_en | output | 2 | Fine cell enables |

## Verification
The assertions check on every rising edge that the thermometer word is a contiguous run from line 0 up. They also check that the weighted sum of the enables equals the sample captured one cycle earlier, that the binary and fine fields match that sample, and that the enables are all low after a sleep edge. Only the bench scenarios can show the half-cycle timing: the old value is held until the falling edge. The same applies to the newest sample appearing on release from sleep and to the clearing and recovery around reset. The sweep over all 4096 codes also confirms that the weighted sum never decreases from one code to the next.

// File: rtl/segdac_pkg.sv
package segdac_pkg;
    localparam int unsigned SEG_W_DEF  = 5;
    localparam int unsigned BIN_W_DEF  = 5;
    localparam int unsigned FINE_W_DEF = 2;
endpackage

// File: rtl/segdac_therm_dec.sv
module segdac_therm_dec #(
    parameter int unsigned SEG_W = 5,
    parameter int unsigned LINES = (1 << SEG_W) - 1
) (
    input  logic [SEG_W-1:0] code_i,
    output logic [LINES-1:0] therm_o
);
    for (genvar k = 0; k < LINES; k++) begin : g_line
        assign therm_o[k] = (code_i > SEG_W'(k));
    end
endmodule

// File: rtl/segdac_capture.sv
module segdac_capture #(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    output logic [DATA_W-1:0] word_o
);
    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = sample_i;
        if (!rst_n) begin
            word_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        word_q <= word_d;
    end

    assign word_o = word_q;
endmodule

// File: rtl/segdac_align.sv
module segdac_align #(
    parameter int unsigned LINES  = 31,
    parameter int unsigned BIN_W  = 5,
    parameter int unsigned FINE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic [LINES-1:0]  therm_i,
    input  logic [BIN_W-1:0]  bin_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic [LINES-1:0]  therm_o,
    output logic [BIN_W-1:0]  bin_o,
    output logic [FINE_W-1:0] fine_o
);
    typedef struct packed {
        logic [LINES-1:0]  therm;
        logic [BIN_W-1:0]  bin;
        logic [FINE_W-1:0] fine;
    } sw_t;

    sw_t sw_d, sw_q;

    always_comb begin
        sw_d.therm = therm_i;
        sw_d.bin   = bin_i;
        sw_d.fine  = fine_i;
        if (!rst_n || sleep_i) begin
            sw_d = '0;
        end
    end

    // second phase: inverse of the capture clock
    always_ff @(negedge clk) begin
        sw_q <= sw_d;
    end

    assign therm_o = sw_q.therm;
    assign bin_o   = sw_q.bin;
    assign fine_o  = sw_q.fine;
endmodule

// File: rtl/segdac_decoder.sv
module segdac_decoder
    import segdac_pkg::*;
#(
    parameter int unsigned SEG_W  = SEG_W_DEF,
    parameter int unsigned BIN_W  = BIN_W_DEF,
    parameter int unsigned FINE_W = FINE_W_DEF,
    parameter int unsigned DATA_W = SEG_W + BIN_W + FINE_W,
    parameter int unsigned LINES  = (1 << SEG_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic [DATA_W-1:0] sample,
    output logic [LINES-1:0]  therm_en,
    output logic [BIN_W-1:0]  bin_en,
    output logic [FINE_W-1:0] fine_en
);
    localparam int unsigned SEG_LO = BIN_W + FINE_W;

    logic [DATA_W-1:0] word;
    logic [LINES-1:0]  therm_dec;

    segdac_capture #(.DATA_W(DATA_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample),
        .word_o   (word)
    );

    segdac_therm_dec #(.SEG_W(SEG_W), .LINES(LINES)) u_dec (
        .code_i  (word[DATA_W-1:SEG_LO]),
        .therm_o (therm_dec)
    );

    segdac_align #(.LINES(LINES), .BIN_W(BIN_W), .FINE_W(FINE_W)) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep_i (sleep),
        .therm_i (therm_dec),
        .bin_i   (word[SEG_LO-1:FINE_W]),
        .fine_i  (word[FINE_W-1:0]),
        .therm_o (therm_en),
        .bin_o   (bin_en),
        .fine_o  (fine_en)
    );
endmodule

// File: rtl/segdac_checker.sv
module segdac_checker #(
    parameter int unsigned SEG_W  = 5,
    parameter int unsigned BIN_W  = 5,
    parameter int unsigned FINE_W = 2,
    parameter int unsigned DATA_W = SEG_W + BIN_W + FINE_W,
    parameter int unsigned LINES  = (1 << SEG_W) - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep,
    input logic [DATA_W-1:0] sample,
    input logic [LINES-1:0]  therm_en,
    input logic [BIN_W-1:0]  bin_en,
    input logic [FINE_W-1:0] fine_en
);
    logic [LINES-1:0]  therm_p1;
    logic [DATA_W-1:0] wsum;

    always_comb begin
        therm_p1 = therm_en + LINES'(1);
        wsum = DATA_W'($countones(therm_en)) << (BIN_W + FINE_W);
        wsum = wsum + (DATA_W'(bin_en) << FINE_W) + DATA_W'(fine_en);
    end

    // R2: lines form a run starting at line 0
    p_therm_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot0(therm_p1));

    // R4: weighted units equal the sample captured one cycle earlier
    p_weight_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !sleep) |-> (wsum == $past(sample)));

    // R3: binary and fine fields follow the captured sample
    p_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !sleep) |->
        ({bin_en, fine_en} == $past(sample[BIN_W+FINE_W-1:0])));

    // R6: every enable is off after a sleep edge
    p_sleep_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sleep) |-> (therm_en == '0 && bin_en == '0 && fine_en == '0));
endmodule

bind segdac_decoder segdac_checker #(
    .SEG_W(SEG_W), .BIN_W(BIN_W), .FINE_W(FINE_W), .DATA_W(DATA_W), .LINES(LINES)
) u_chk (.*);

// File: tb/tb_segdac_decoder.sv
module tb_segdac_decoder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sleep;
    logic [11:0] sample;
    logic [30:0] therm_en;
    logic [4:0]  bin_en;
    logic [1:0]  fine_en;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    segdac_decoder dut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .sample(sample),
        .therm_en(therm_en), .bin_en(bin_en), .fine_en(fine_en)
    );

    function automatic logic [37:0] expect_word(input logic [11:0] c);
        logic [30:0] t;
        for (int k = 0; k < 31; k++) t[k] = (int'(c[11:7]) > k);
        return {t, c[6:2], c[1:0]};
    endfunction

    function automatic int weight_of(input logic [30:0] t, input logic [4:0] b, input logic [1:0] f);
        int w = 0;
        for (int k = 0; k < 31; k++) w += t[k] ? 128 : 0;
        for (int i = 0; i < 5; i++) w += b[i] ? (4 << i) : 0;
        return w + int'(f);
    endfunction

    task automatic check(input string req, input logic [37:0] exp);
        checks++;
        if ({therm_en, bin_en, fine_en} !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h at %0t", req,
                     {therm_en, bin_en, fine_en}, exp, $time);
        end
    endtask

    task automatic drive(input logic [11:0] c);
        @(posedge clk); #1;
        sample = c;
    endtask

    task automatic to_out();
        @(posedge clk);
        @(negedge clk); #1;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int prev_w;
        logic [11:0] prev_c;
        rst_n = 1'b0; sleep = 1'b0; sample = 12'h5A5;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check("R8 reset state", '0);
        @(posedge clk); #1;
        rst_n = 1'b1;

        // R1 R2 R3 R5: exhaustive sweep, latency and field layout
        prev_c = 12'h000;
        drive(12'h000); to_out();
        check("R1", expect_word(12'h000));
        prev_w = 0;
        for (int c = 1; c < 4096; c++) begin
            drive(12'(c));
            @(posedge clk); #1;
            check("R5 hold before falling edge", expect_word(prev_c));
            @(negedge clk); #1;
            check("R2 R3 decode", expect_word(12'(c)));
            checks++;
            if (weight_of(therm_en, bin_en, fine_en) != c ||
                weight_of(therm_en, bin_en, fine_en) < prev_w) begin
                errors++;
                $display("FAIL R4: got weight %0d expected %0d",
                         weight_of(therm_en, bin_en, fine_en), c);
            end
            prev_w = weight_of(therm_en, bin_en, fine_en);
            prev_c = 12'(c);
        end

        // R6 R7: sleep forces off, release shows newest sample
        drive(12'hABC); to_out();
        check("R6 pre-sleep", expect_word(12'hABC));
        @(posedge clk); #1;
        sleep = 1'b1; sample = 12'h123;
        @(negedge clk); #1;
        check("R6 sleep off", '0);
        sample = 12'hF0F;
        to_out();
        check("R6 sleep held", '0);
        @(posedge clk); #1;
        sleep = 1'b0;
        check("R7 still off before falling edge", '0);
        @(negedge clk); #1;
        check("R7 resume newest", expect_word(12'hF0F));

        // R8: reset mid-stream clears, then recovers
        drive(12'hFFF); to_out();
        check("R8 pre-reset", expect_word(12'hFFF));
        @(posedge clk); #1;
        rst_n = 1'b0;
        @(negedge clk); #1;
        check("R8 cleared", '0);
        to_out();
        check("R8 held clear", '0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        to_out();
        check("R8 recovery", expect_word(12'hFFF));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule